// File: doc/BRIEF.md
# State-Preserving Bypass Crossbar Switch

This block is the switch stage of a four-port mesh router. It keeps a stored default connection pattern: for every input, the output that input is tied to when no allocation is taking place. A flit whose requested output matches that stored connection crosses the switch without routing, virtual-channel or switch allocation. It is registered straight onto the output link, so its hop takes one cycle. Any other flit is parked in a one-entry input stage and raises a request towards an external switch allocator. When the allocator grants it, the flit moves through a traversal register and then onto the link. A flit granted at once therefore takes three cycles.

The stored pattern is held in a port state table that must be a permutation of the outputs, so that no two inputs share an output. A controller loads it, and a load that breaks the permutation is refused. For each output, the preserved connection applies only when that output was not granted by the allocator in the previous cycle. In that case the allocated flit owns the output, and any matching flit on that output is sent down the normal path instead. Upstream senders present a flit on an input only while that input reports it is ready.

Top module: `stateBypassXbar`

## Requirements
- R1: After reset the table maps input i to output i. All link outputs are idle, every input reports ready, and no request is raised.
- R2: A flit presented on input i with `inValid[i]` and `inDest` equal to table entry i is registered onto that output link with its data in the next cycle. This holds when that output was not granted in the previous cycle.
- R3: A flit that does not bypass is held in the input stage from the next cycle on. While it is held, `reqValid[i]` is high, `reqDest` gives its output and `inReady[i]` is low, and this lasts until a grant for that input arrives. Senders drive `inValid[i]` only while `inReady[i]` is high.
- R4: A grant for output o naming input i in cycle c puts that input's held flit on link o in cycle c+2, and the input is ready again from cycle c+1. A flit granted in the cycle after it arrives therefore sees a three-cycle latency.
- R5: If output o was granted in the previous cycle, a flit that would otherwise bypass to o is instead held and requested as in R3. The output carries the allocated flit, and the held flit follows later.
- R6: While `tblLoad` is high, `tblData` holds the output for input i at bits [2i+1:2i]. A load that forms a permutation takes effect from the next cycle.
- R7: A load in which two entries name the same output is refused, and the previous table stays in force.
- R8: With several inputs active at once, each flit appears exactly once, on its requested output and with its data. An output carries at most one flit per cycle. Flits held for the same output leave in the order the allocator grants them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Flit present on each input |
| inData | input | 4×DATA_W | Flit payload, input i at bits [i·DATA_W +: DATA_W] |
| inDest | input | 8 | Requested output, input i at bits [2i+1:2i] |
| inReady | output | 4 | Input stage empty, a flit may be presented |
| reqValid | output | 4 | Held flit requesting the allocator |
| reqDest | output | 8 | Output requested by each held flit |
| gntValid | input | 4 | Allocator grant for each output |
| gntInput | input | 8 | Input granted for output o at bits [2o+1:2o] |
| tblLoad | input | 1 | Load a new port state table |
| tblData | input | 8 | New table, entry i at bits [2i+1:2i] |
| linkValid | output | 4 | Flit on each output link |
| linkData | output | 4×DATA_W | Link payload per output |

## Verification
The assertions check four things on every cycle. Each presented flit either lands on its requested link one cycle later or shows up as a held request. A held request stays stable until it is granted. Every grant puts a flit on the link two cycles later. No matching flit bypasses onto an output granted in the cycle before. The bench scenarios cover the rest. One checks the exact per-path latency of mixed traffic and that nothing unexpected appears on any output. One checks that a grant-versus-bypass collision leaves the allocated flit first. Others check that table loads are applied or refused, which can only be seen through how later flits are routed.

// File: rtl/bypassXbarPkg.sv
package bypassXbarPkg;
  localparam int NUM_PORTS = 4;
  localparam int PORT_W = $clog2(NUM_PORTS);

  typedef logic [PORT_W-1:0] portIdx_t;

  // Strobes from control to datapath, one bit or index per input/output
  typedef struct packed {
    logic [NUM_PORTS-1:0]     bufLoad;   // per input: capture flit in input stage
    logic [NUM_PORTS-1:0]     bufClear;  // per input: held flit granted
    logic [NUM_PORTS-1:0]     xLoad;     // per output: traversal register loads
    portIdx_t [NUM_PORTS-1:0] xSrc;      // per output: granted input
    logic [NUM_PORTS-1:0]     bypEn;     // per output: bypass flit goes to link
    portIdx_t [NUM_PORTS-1:0] bypSrc;    // per output: input using preserved path
  } xbarStrobes_t;
endpackage

// File: rtl/bypassCtrl.sv
module bypassCtrl
  import bypassXbarPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        inValid,
  input  logic [NUM_PORTS*PORT_W-1:0] inDest,
  input  logic [NUM_PORTS-1:0]        gntValid,
  input  logic [NUM_PORTS*PORT_W-1:0] gntInput,
  input  logic                        tblLoad,
  input  logic [NUM_PORTS*PORT_W-1:0] tblData,
  output xbarStrobes_t                strobes
);
  localparam int N = NUM_PORTS;
  localparam int PW = PORT_W;
  localparam logic [N-1:0] ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};

  portIdx_t       tbl [N];
  logic [N-1:0]   allocLast;
  logic [N-1:0]   dec [N];
  logic [N-1:0]   bypSel [N];
  logic [N-1:0]   match;
  logic [N-1:0]   bypassed;
  logic [N-1:0]   seen;
  logic           tblOk;
  portIdx_t       ent;

  // Permutation check on a requested load
  always_comb begin
    seen  = '0;
    tblOk = 1'b1;
    ent   = '0;
    for (int i = 0; i < N; i++) begin
      ent = tblData[i*PW +: PW];
      if (seen[ent]) tblOk = 1'b0;
      seen[ent] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) tbl[i] <= portIdx_t'(i);
      allocLast <= '0;
    end else begin
      if (tblLoad && tblOk)
        for (int i = 0; i < N; i++) tbl[i] <= tblData[i*PW +: PW];
      allocLast <= gntValid;
    end
  end

  // One decoder per table entry, transposed into per-output select lines
  for (genvar gi = 0; gi < N; gi++) begin : g_dec
    assign dec[gi]   = ONE_HOT0 << tbl[gi];
    assign match[gi] = inValid[gi] && (inDest[gi*PW +: PW] == tbl[gi]);
    assign bypassed[gi] = match[gi] && !allocLast[tbl[gi]];
  end

  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++) bypSel[o][i] = dec[i][o];
  end

  always_comb begin
    strobes = '0;
    strobes.bufLoad = inValid & ~bypassed;
    strobes.xLoad   = gntValid;
    for (int o = 0; o < N; o++) begin
      strobes.xSrc[o]  = gntInput[o*PW +: PW];
      strobes.bypEn[o] = |(bypSel[o] & bypassed);
      for (int i = 0; i < N; i++) begin
        if (bypSel[o][i]) strobes.bypSrc[o] = portIdx_t'(i);
        if (gntValid[o] && (gntInput[o*PW +: PW] == portIdx_t'(i)))
          strobes.bufClear[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bypassDatapath.sv
module bypassDatapath
  import bypassXbarPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xbarStrobes_t                strobes,
  input  logic [NUM_PORTS*DATA_W-1:0] inData,
  input  logic [NUM_PORTS*PORT_W-1:0] inDest,
  output logic [NUM_PORTS-1:0]        inReady,
  output logic [NUM_PORTS-1:0]        reqValid,
  output logic [NUM_PORTS*PORT_W-1:0] reqDest,
  output logic [NUM_PORTS-1:0]        linkValid,
  output logic [NUM_PORTS*DATA_W-1:0] linkData
);
  localparam int N = NUM_PORTS;
  localparam int PW = PORT_W;

  logic [DATA_W-1:0] inArr [N];
  logic [N-1:0]      bufValid;
  logic [DATA_W-1:0] bufData [N];
  portIdx_t          bufDest [N];
  logic [N-1:0]      xValid;
  logic [DATA_W-1:0] xData [N];
  logic [DATA_W-1:0] linkArr [N];

  always_comb begin
    for (int i = 0; i < N; i++) inArr[i] = inData[i*DATA_W +: DATA_W];
  end

  // Input stage: one flit per input waiting for a grant
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rstN)                    bufValid[i] <= 1'b0;
      else if (strobes.bufLoad[i])  bufValid[i] <= 1'b1;
      else if (strobes.bufClear[i]) bufValid[i] <= 1'b0;
      if (strobes.bufLoad[i]) begin
        bufData[i] <= inArr[i];
        bufDest[i] <= inDest[i*PW +: PW];
      end
    end
  end

  // Traversal stage, then link register shared by both paths
  always_ff @(posedge clk) begin
    for (int o = 0; o < N; o++) begin
      if (!rstN) begin
        xValid[o]    <= 1'b0;
        linkValid[o] <= 1'b0;
        linkArr[o]   <= '0;
      end else begin
        xValid[o]    <= strobes.xLoad[o];
        linkValid[o] <= xValid[o] | strobes.bypEn[o];
        if (xValid[o])               linkArr[o] <= xData[o];
        else if (strobes.bypEn[o])   linkArr[o] <= inArr[strobes.bypSrc[o]];
      end
      if (strobes.xLoad[o]) xData[o] <= bufData[strobes.xSrc[o]];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      inReady[i]            = !bufValid[i];
      reqValid[i]           = bufValid[i];
      reqDest[i*PW +: PW]   = bufDest[i];
      linkData[i*DATA_W +: DATA_W] = linkArr[i];
    end
  end
endmodule

// File: rtl/stateBypassXbar.sv
module stateBypassXbar
  import bypassXbarPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        inValid,
  input  logic [NUM_PORTS*DATA_W-1:0] inData,
  input  logic [NUM_PORTS*PORT_W-1:0] inDest,
  output logic [NUM_PORTS-1:0]        inReady,
  output logic [NUM_PORTS-1:0]        reqValid,
  output logic [NUM_PORTS*PORT_W-1:0] reqDest,
  input  logic [NUM_PORTS-1:0]        gntValid,
  input  logic [NUM_PORTS*PORT_W-1:0] gntInput,
  input  logic                        tblLoad,
  input  logic [NUM_PORTS*PORT_W-1:0] tblData,
  output logic [NUM_PORTS-1:0]        linkValid,
  output logic [NUM_PORTS*DATA_W-1:0] linkData
);
  xbarStrobes_t strobes;

  bypassCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inDest   (inDest),
    .gntValid (gntValid),
    .gntInput (gntInput),
    .tblLoad  (tblLoad),
    .tblData  (tblData),
    .strobes  (strobes)
  );

  bypassDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inData    (inData),
    .inDest    (inDest),
    .inReady   (inReady),
    .reqValid  (reqValid),
    .reqDest   (reqDest),
    .linkValid (linkValid),
    .linkData  (linkData)
  );
endmodule

// File: rtl/xbarBypassChecker.sv
module xbarBypassChecker
  import bypassXbarPkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PORTS-1:0]        inValid,
  input logic [NUM_PORTS*DATA_W-1:0] inData,
  input logic [NUM_PORTS*PORT_W-1:0] inDest,
  input logic [NUM_PORTS-1:0]        inReady,
  input logic [NUM_PORTS-1:0]        reqValid,
  input logic [NUM_PORTS*PORT_W-1:0] reqDest,
  input logic [NUM_PORTS-1:0]        gntValid,
  input logic [NUM_PORTS*PORT_W-1:0] gntInput,
  input logic [NUM_PORTS-1:0]        linkValid,
  input logic [NUM_PORTS*DATA_W-1:0] linkData
);
  localparam int N = NUM_PORTS;
  localparam int PW = PORT_W;

  logic [N-1:0] gotGnt;
  always_comb begin
    gotGnt = '0;
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        if (gntValid[o] && gntInput[o*PW +: PW] == portIdx_t'(i)) gotGnt[i] = 1'b1;
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_in
    // R2
    bypass_one_hop_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid[gi] |=> (reqValid[gi] ||
        (linkValid[$past(inDest[gi*PW +: PW])] &&
         linkData[$past(inDest[gi*PW +: PW])*DATA_W +: DATA_W] == $past(inData[gi*DATA_W +: DATA_W]))));
    // R3
    sender_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid[gi] |-> inReady[gi]);
    // R3
    request_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[gi] && !gotGnt[gi]) |=> (reqValid[gi] && $stable(reqDest[gi*PW +: PW])));
    for (genvar go = 0; go < N; go++) begin : g_out
      // R5
      no_bypass_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(gntValid[go]) && inValid[gi] && inDest[gi*PW +: PW] == portIdx_t'(go))
          |=> reqValid[gi]);
    end
  end

  for (genvar go = 0; go < N; go++) begin : g_link
    // R4
    grant_reaches_link_chk: assert property (@(posedge clk) disable iff (!rstN)
      gntValid[go] |-> ##2 linkValid[go]);
  end
endmodule

bind stateBypassXbar xbarBypassChecker #(.DATA_W(DATA_W)) u_xbarChk (.*);

// File: tb/test_stateBypassXbar.sv
`timescale 1ns/1ps
module test_stateBypassXbar;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  inValid = '0;
  logic [N*DW-1:0] inData = '0;
  logic [N*PW-1:0] inDest = '0;
  logic [N-1:0]  inReady, reqValid, linkValid;
  logic [N*PW-1:0] reqDest;
  logic [N-1:0]  gntValid;
  logic [N*PW-1:0] gntInput;
  logic          tblLoad = 1'b0;
  logic [N*PW-1:0] tblData = '0;
  logic [N*DW-1:0] linkData;
  logic          allocEn = 1'b1;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  stateBypassXbar #(.DATA_W(DW)) i_stateBypassXbar (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inDest(inDest),
    .inReady(inReady), .reqValid(reqValid), .reqDest(reqDest),
    .gntValid(gntValid), .gntInput(gntInput), .tblLoad(tblLoad), .tblData(tblData),
    .linkValid(linkValid), .linkData(linkData));

  // Stand-in allocator: each output grants the lowest requesting input
  always_comb begin
    gntValid = '0;
    gntInput = '0;
    if (allocEn)
      for (int o = 0; o < N; o++)
        for (int i = N - 1; i >= 0; i--)
          if (reqValid[i] && int'(reqDest[i*PW +: PW]) == o) begin
            gntValid[o] = 1'b1;
            gntInput[o*PW +: PW] = 2'(i);
          end
  end

  // valid[23:20], dest[19:12] (2 bits per input), latency[11:0] (3 bits per input)
  localparam logic [23:0] VEC [7] = '{
    {4'h1, 8'h00, 12'h001},
    {4'hF, 8'hE4, 12'h249},
    {4'h1, 8'h01, 12'h003},
    {4'h3, 8'h05, 12'h00B},
    {4'hD, 8'h51, 12'hB03},
    {4'h3, 8'h01, 12'h01B},
    {4'h9, 8'h00, 12'h601}
  };

  function automatic logic [31:0] tagOf(input int v, input int i);
    return 32'hC0DE0000 | 32'(v * 16 + i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearIn();
    inValid = '0;
    inDest  = '0;
    inData  = '0;
  endtask

  // Launch one set of flits, then compare every output for six cycles
  task automatic runVec(input logic [3:0] valid, input logic [7:0] dest, input logic [11:0] lat, input int v);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      inValid[i] = valid[i];
      inDest[i*PW +: PW] = dest[i*PW +: PW];
      inData[i*DW +: DW] = tagOf(v, i);
    end
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) clearIn();
      for (int o = 0; o < N; o++) begin
        logic ev;
        logic [31:0] ed;
        string rq;
        ev = 1'b0; ed = '0; rq = "R8";
        for (int i = 0; i < N; i++)
          if (valid[i] && int'(dest[i*PW +: PW]) == o && int'(lat[i*3 +: 3]) == k) begin
            ev = 1'b1; ed = tagOf(v, i);
            rq = (k == 1) ? "R2" : "R4";
          end
        chk(linkValid[o] == ev && (!ev || linkData[o*DW +: DW] == ed), rq,
            {31'd0, linkValid[o], linkData[o*DW +: DW]}, {31'd0, ev, ed});
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(linkValid == 4'h0, "R1", 64'(linkValid), 64'h0);
    chk(inReady == 4'hF, "R1", 64'(inReady), 64'hF);
    chk(reqValid == 4'h0, "R1", 64'(reqValid), 64'h0);
    // R1 identity table seen through bypass: in3 to out3 in one cycle
    runVec(4'h8, 8'hC0, 12'h200, 30);

    for (int v = 0; v < 7; v++) runVec(VEC[v][23:20], VEC[v][19:12], VEC[v][11:0], v);

    // R3: held flit requests and stays while the allocator is idle
    allocEn = 1'b0;
    @(negedge clk);
    inValid[1] = 1'b1; inDest[3:2] = 2'd3; inData[63:32] = 32'hFEED0001;
    @(negedge clk);
    clearIn();
    chk(reqValid[1] && reqDest[3:2] == 2'd3, "R3", {62'd0, reqDest[3:2]}, 64'd3);
    chk(!inReady[1], "R3", 64'(inReady), 64'hD);
    repeat (2) @(negedge clk);
    chk(reqValid[1] && reqDest[3:2] == 2'd3 && linkValid == 4'h0, "R3",
        {59'd0, reqValid[1], linkValid}, {59'd0, 1'b1, 4'h0});
    allocEn = 1'b1;                       // grant in this cycle (R4)
    @(negedge clk);
    chk(inReady[1] && !linkValid[3], "R4", {62'd0, inReady[1], linkValid[3]}, 64'h2);
    @(negedge clk);
    chk(linkValid[3] && linkData[127:96] == 32'hFEED0001, "R4", 64'(linkData[127:96]), 64'hFEED0001);

    // R5: grant on out2 blocks a matching flit in the next cycle
    @(negedge clk);
    inValid[1] = 1'b1; inDest[3:2] = 2'd2; inData[63:32] = 32'hAAAA0001;
    @(negedge clk);
    clearIn();
    @(negedge clk);
    inValid[2] = 1'b1; inDest[5:4] = 2'd2; inData[95:64] = 32'hBBBB0002;
    @(negedge clk);
    clearIn();
    chk(linkValid[2] && linkData[95:64] == 32'hAAAA0001, "R5", 64'(linkData[95:64]), 64'hAAAA0001);
    chk(reqValid[2], "R5", 64'(reqValid), 64'h4);
    @(negedge clk);
    chk(!linkValid[2], "R5", 64'(linkValid), 64'h0);
    @(negedge clk);
    chk(linkValid[2] && linkData[95:64] == 32'hBBBB0002, "R5", 64'(linkData[95:64]), 64'hBBBB0002);
    repeat (3) @(negedge clk);

    // R6: load rotation in0->1, in1->2, in2->3, in3->0
    tblLoad = 1'b1; tblData = 8'h39;
    @(negedge clk);
    tblLoad = 1'b0;
    runVec(4'hB, 8'h05, 12'h219, 20);

    // R7: duplicate entries refused, rotation still applies
    @(negedge clk);
    tblLoad = 1'b1; tblData = 8'h09;
    @(negedge clk);
    tblLoad = 1'b0;
    runVec(4'h5, 8'h01, 12'h0C1, 21);
    @(negedge clk);
    tblLoad = 1'b1; tblData = 8'h00;
    @(negedge clk);
    tblLoad = 1'b0;
    runVec(4'h4, 8'h30, 12'h040, 22);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule